// File: doc/BRIEF.md
# Segment Offset Limit and Rights Checker

This block checks one memory access against the cached attributes of a segment. It raises a fault when the access would fall outside the segment's valid offset range, or when the access type is not allowed by the segment's rights bits. Alongside the check it forms the linear address as segment base plus offset. The check is combinational: the fault flag and the linear address follow the inputs in the same cycle.

The block also holds the stack pointer and updates it for implicit push and pop operations. These operations always use the stack segment's cached fields. The stack segment's big bit chooses the pointer arithmetic: either the 16-bit low half of the pointer or the full 32-bit pointer. The address-size attribute of the instruction plays no part. A faulting stack operation leaves the pointer unchanged.

Top module: `seg_access_check`

## Requirements
- R1: For an expand-up segment (expand bit 0), an access of N bytes at offset O passes the limit check only when O+N-1 is at most the limit. An O+N-1 that wraps past FFFFFFFF is a fault.
- R2: For an expand-down segment (expand bit 1), every byte offset must be strictly greater than the limit. With limit 0, a 1-byte access at offset 0 faults and one at offset 1 passes.
- R3: For an expand-down segment, the last byte offset must not exceed 0000FFFF when the big bit is 0, or FFFFFFFF when it is 1.
- R4: When protected mode is on (`pe`=1), a write to an executable segment (`seg_x`=1) faults. With `pe`=0, the same write passes.
- R5: When `pe`=1, a read of an executable segment faults if its readable bit is 0, and passes if that bit is 1.
- R6: When `pe`=1, a write to a data segment (`seg_x`=0) faults if its writable bit is 0. A read of the same segment passes.
- R7: `lin_addr` is the selected segment base plus the checked offset, modulo 2^32.
- R8: A push of N bytes computes pointer-N and a pop uses the current pointer. The pop then adds N. With `ss_b`=0 only bits 15:0 of the pointer change, bits 31:16 are kept, and the offset is the zero-extended low half. With `ss_b`=1 all 32 bits are used.
- R9: Push and pop use the `ss_*` fields as the segment and ignore `acc_off`, `acc_wr` and all `seg_*` inputs. A push is checked as a write and a pop as a read. If both are asserted, the push wins.
- R10: A push or pop that faults leaves the pointer unchanged. `esp_load` overrides push and pop, and loads `esp_wdata` on the next edge.
- R11: After reset the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pe | input | 1 | Protected mode enabled |
| acc_off | input | 32 | Effective offset of an explicit access |
| acc_size | input | 3 | Access size in bytes: 1, 2 or 4 |
| acc_wr | input | 1 | 1 for a write, 0 for a read (explicit access) |
| seg_base | input | 32 | Cached base of the addressed segment |
| seg_limit | input | 32 | Cached byte limit of the addressed segment |
| seg_e | input | 1 | Expand-down bit of the addressed segment |
| seg_b | input | 1 | Big bit of the addressed segment |
| seg_x | input | 1 | Executable bit |
| seg_r | input | 1 | Readable bit (code segments) |
| seg_w | input | 1 | Writable bit (data segments) |
| ss_base | input | 32 | Cached stack segment base |
| ss_limit | input | 32 | Cached stack segment limit |
| ss_e | input | 1 | Stack segment expand-down bit |
| ss_b | input | 1 | Stack segment big bit (pointer width) |
| ss_w | input | 1 | Stack segment writable bit |
| stk_push | input | 1 | Implicit push of `acc_size` bytes |
| stk_pop | input | 1 | Implicit pop of `acc_size` bytes |
| esp_load | input | 1 | Load the stack pointer |
| esp_wdata | input | 32 | Value for `esp_load` |
| fault | output | 1 | Access violates limit or rights |
| lin_addr | output | 32 | Base plus offset |
| esp | output | 32 | Current stack pointer |

## Verification
The hardest case to reach is a 16-bit stack push that wraps the low half of the pointer. The high half must stay intact while the offset becomes 0000FFFE. A second hard case is the same wrap landing beside the 0000FFFF bound of an expand-down stack. Both are reached by loading the pointer with a value whose low half is zero and a non-zero high half, then pushing against an expand-down stack segment. A faulting push is forced by clearing the stack's writable bit. The bench then reads the pointer back on the next cycle to confirm that nothing changed.

// File: rtl/seg_access_check.sv
module seg_access_check #(
  parameter int AW  = 32,
  parameter int SPW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pe,
  input  logic [AW-1:0] acc_off,
  input  logic [2:0]    acc_size,
  input  logic          acc_wr,
  input  logic [AW-1:0] seg_base,
  input  logic [AW-1:0] seg_limit,
  input  logic          seg_e,
  input  logic          seg_b,
  input  logic          seg_x,
  input  logic          seg_r,
  input  logic          seg_w,
  input  logic [AW-1:0] ss_base,
  input  logic [AW-1:0] ss_limit,
  input  logic          ss_e,
  input  logic          ss_b,
  input  logic          ss_w,
  input  logic          stk_push,
  input  logic          stk_pop,
  input  logic          esp_load,
  input  logic [AW-1:0] esp_wdata,
  output logic          fault,
  output logic [AW-1:0] lin_addr,
  output logic [AW-1:0] esp
);
  localparam logic [AW-1:0] SMALL_TOP = AW'({SPW{1'b1}});

  logic          use_stk, wr_eff, x_eff, r_eff, w_eff, e_eff, b_eff;
  logic [AW-1:0] step, esp_dec, esp_inc, push_next, pop_next, stk_raw, stk_off;
  logic [AW-1:0] off, lim, base, hi_bound;
  logic [AW:0]   last;
  logic          up_bad, dn_bad, lim_bad, rights_bad;

  assign use_stk = stk_push | stk_pop;
  assign step    = AW'(acc_size);
  assign esp_dec = esp - step;
  assign esp_inc = esp + step;

  assign push_next = ss_b ? esp_dec : {esp[AW-1:SPW], esp_dec[SPW-1:0]};
  assign pop_next  = ss_b ? esp_inc : {esp[AW-1:SPW], esp_inc[SPW-1:0]};
  assign stk_raw   = stk_push ? push_next : esp;
  assign stk_off   = ss_b ? stk_raw : AW'(stk_raw[SPW-1:0]);

  assign off    = use_stk ? stk_off  : acc_off;
  assign lim    = use_stk ? ss_limit : seg_limit;
  assign base   = use_stk ? ss_base  : seg_base;
  assign e_eff  = use_stk ? ss_e     : seg_e;
  assign b_eff  = use_stk ? ss_b     : seg_b;
  assign wr_eff = use_stk ? stk_push : acc_wr;
  assign x_eff  = use_stk ? 1'b0     : seg_x;
  assign r_eff  = use_stk ? 1'b1     : seg_r;
  assign w_eff  = use_stk ? ss_w     : seg_w;

  assign last     = {1'b0, off} + {1'b0, step} - {{AW{1'b0}}, 1'b1};
  assign hi_bound = b_eff ? {AW{1'b1}} : SMALL_TOP;
  assign up_bad   = last[AW] | (last[AW-1:0] > lim);
  assign dn_bad   = (off <= lim) | last[AW] | (last[AW-1:0] > hi_bound);
  assign lim_bad  = e_eff ? dn_bad : up_bad;

  assign rights_bad = pe & ((wr_eff & x_eff) |
                            (~wr_eff & x_eff & ~r_eff) |
                            (wr_eff & ~x_eff & ~w_eff));

  assign fault    = lim_bad | rights_bad;
  assign lin_addr = base + off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 esp <= '0;
    else if (esp_load)          esp <= esp_wdata;
    else if (stk_push && !fault) esp <= push_next;
    else if (stk_pop && !fault)  esp <= pop_next;
  end

  a_r4_exec_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!stk_push && !stk_pop && pe && acc_wr && seg_x) |-> fault);

  a_r1_expup_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (!stk_push && !stk_pop && !seg_e && !fault) |->
      ({1'b0, acc_off} + {30'b0, acc_size} <= {1'b0, seg_limit} + 33'd1));

  a_r2_expdown_above: assert property (@(posedge clk) disable iff (!rst_n)
    (!stk_push && !stk_pop && seg_e && !fault) |-> (acc_off > seg_limit));

  a_r7_linear: assert property (@(posedge clk) disable iff (!rst_n)
    (!stk_push && !stk_pop) |-> (lin_addr == seg_base + acc_off));

  a_r10_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((stk_push || stk_pop) && fault && !esp_load) |=> $stable(esp));

  a_r8_small_high_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ((stk_push || stk_pop) && !ss_b && !esp_load) |=> (esp[AW-1:SPW] == $past(esp[AW-1:SPW])));
endmodule

// File: tb/test_seg_access_check.sv
module test_seg_access_check;
  logic clk = 0, rst_n = 0;
  logic pe, acc_wr, seg_e, seg_b, seg_x, seg_r, seg_w, ss_e, ss_b, ss_w;
  logic stk_push, stk_pop, esp_load;
  logic [2:0]  acc_size;
  logic [31:0] acc_off, seg_base, seg_limit, ss_base, ss_limit, esp_wdata;
  logic        fault;
  logic [31:0] lin_addr, esp;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  seg_access_check i_seg_access_check (
    .clk(clk), .rst_n(rst_n), .pe(pe), .acc_off(acc_off), .acc_size(acc_size),
    .acc_wr(acc_wr), .seg_base(seg_base), .seg_limit(seg_limit), .seg_e(seg_e),
    .seg_b(seg_b), .seg_x(seg_x), .seg_r(seg_r), .seg_w(seg_w),
    .ss_base(ss_base), .ss_limit(ss_limit), .ss_e(ss_e), .ss_b(ss_b), .ss_w(ss_w),
    .stk_push(stk_push), .stk_pop(stk_pop), .esp_load(esp_load),
    .esp_wdata(esp_wdata), .fault(fault), .lin_addr(lin_addr), .esp(esp));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic data_seg(input logic [31:0] lim, input logic e, input logic b);
    seg_base = 32'h1000; seg_limit = lim; seg_e = e; seg_b = b;
    seg_x = 0; seg_r = 0; seg_w = 1;
  endtask

  task automatic access(input logic [31:0] off, input logic [2:0] sz, input logic wr);
    @(negedge clk);
    acc_off = off; acc_size = sz; acc_wr = wr;
    #1;
  endtask

  task automatic load_esp(input logic [31:0] v);
    @(negedge clk); esp_load = 1; esp_wdata = v;
    @(negedge clk); esp_load = 0;
  endtask

  task automatic stack_op(input logic push, input logic [2:0] sz);
    @(negedge clk);
    stk_push = push; stk_pop = !push; acc_size = sz;
    #1;
  endtask

  task automatic stack_end();
    @(negedge clk); stk_push = 0; stk_pop = 0;
  endtask

  task automatic t_reset();
    chk("R11 reset pointer", esp, 32'h0);
  endtask

  task automatic t_expand_up();
    pe = 1; data_seg(32'hFF, 0, 0);
    access(32'hFC, 4, 0); chk("R1 last byte at limit", fault, 0);
    access(32'hFD, 4, 0); chk("R1 last byte past limit", fault, 1);
    data_seg(32'hFFFF_FFFF, 0, 1);
    access(32'hFFFF_FFFE, 4, 0); chk("R1 wrap faults", fault, 1);
    access(32'hFFFF_FFFC, 4, 0); chk("R1 top of space", fault, 0);
  endtask

  task automatic t_expand_down();
    data_seg(32'h0, 1, 0);
    access(32'h0, 1, 0); chk("R2 offset 0 limit 0", fault, 1);
    access(32'h1, 1, 0); chk("R2 offset 1 limit 0", fault, 0);
    data_seg(32'h100, 1, 0);
    access(32'h100, 1, 0); chk("R2 offset equal limit", fault, 1);
    access(32'hFFFE, 2, 0); chk("R3 small bound edge", fault, 0);
    access(32'hFFFF, 2, 0); chk("R3 small bound crossed", fault, 1);
    data_seg(32'h100, 1, 1);
    access(32'hFFFF, 2, 0); chk("R3 big bound allows", fault, 0);
    access(32'hFFFF_FFFD, 4, 0); chk("R3 big bound crossed", fault, 1);
  endtask

  task automatic t_rights();
    data_seg(32'hFFFF, 0, 0); seg_x = 1; seg_r = 1;
    access(32'h10, 1, 1); chk("R4 write exec pe=1", fault, 1);
    pe = 0; access(32'h11, 1, 1); chk("R4 write exec pe=0", fault, 0);
    pe = 1; seg_r = 0;
    access(32'h10, 2, 0); chk("R5 read exec-only", fault, 1);
    seg_r = 1; access(32'h12, 2, 0); chk("R5 read readable code", fault, 0);
    data_seg(32'hFFFF, 0, 0); seg_w = 0;
    access(32'h10, 4, 1); chk("R6 write read-only data", fault, 1);
    access(32'h14, 4, 0); chk("R6 read read-only data", fault, 0);
  endtask

  task automatic t_linear();
    data_seg(32'hFFFF_FFFF, 0, 1); seg_base = 32'hF000_0000;
    access(32'h2000_0010, 1, 0); chk("R7 modular sum", lin_addr, 32'h1000_0010);
  endtask

  task automatic t_stack();
    ss_base = 32'h0050_0000; ss_limit = 32'h0; ss_e = 1; ss_b = 0; ss_w = 1;
    seg_x = 1; seg_w = 0; seg_base = 32'hDEAD_0000; acc_off = 32'h5; acc_wr = 0;
    load_esp(32'h1234_0000);
    stack_op(1, 2);
    chk("R8 small push offset", lin_addr, 32'h0050_FFFE);
    chk("R9 push ignores seg fields", fault, 0);
    stack_end();
    chk("R8 small push keeps high half", esp, 32'h1234_FFFE);
    stack_op(0, 2);
    chk("R8 small pop offset", lin_addr, 32'h0050_FFFE);
    stack_end();
    chk("R8 small pop wraps low half", esp, 32'h1234_0000);
    ss_b = 1; ss_e = 0; ss_limit = 32'hFFFF_FFFF;
    load_esp(32'h0000_1000);
    stack_op(1, 4);
    chk("R8 big push offset", lin_addr, 32'h0050_0FFC);
    stack_end();
    chk("R8 big push pointer", esp, 32'h0000_0FFC);
    ss_w = 0;
    stack_op(1, 4);
    chk("R10 push to read-only stack", fault, 1);
    stack_end();
    chk("R10 pointer held on fault", esp, 32'h0000_0FFC);
    ss_w = 1; ss_limit = 32'h0FFC;
    stack_op(0, 4);
    chk("R10 pop beyond limit", fault, 1);
    stack_end();
    chk("R10 pointer held on pop fault", esp, 32'h0000_0FFC);
    ss_limit = 32'hFFFF_FFFF;
    @(negedge clk); stk_push = 1; stk_pop = 1; acc_size = 4;
    @(negedge clk); stk_push = 0; stk_pop = 0;
    chk("R9 push wins over pop", esp, 32'h0000_0FF8);
    @(negedge clk); stk_push = 1; acc_size = 4; esp_load = 1; esp_wdata = 32'hA5A5_0000;
    @(negedge clk); stk_push = 0; esp_load = 0;
    chk("R10 load overrides push", esp, 32'hA5A5_0000);
  endtask

  initial begin
    pe = 1; acc_off = 0; acc_size = 1; acc_wr = 0;
    seg_base = 0; seg_limit = 0; seg_e = 0; seg_b = 0; seg_x = 0; seg_r = 0; seg_w = 0;
    ss_base = 0; ss_limit = 0; ss_e = 0; ss_b = 0; ss_w = 1;
    stk_push = 0; stk_pop = 0; esp_load = 0; esp_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_expand_up();
    t_expand_down();
    t_rights();
    t_linear();
    t_stack();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule